// File: doc/BRIEF.md
# Sticky Fault Status and Alert Masking Unit

This block collects live out-of-limit flags from a monitoring device and turns them into sticky status bits that software reads over a small register port. Five measurement channels feed one status register, and four auxiliary fault sources feed a second one. A summary bit shows whether any channel status bit is set. Each status source has its own mask bit, and the summary bit has a separate mask. An active-low alert output is driven from the status and mask registers.

A read strobe on a status address returns the value the register held before the read. In the same clock the read clears every bit of that register whose live fault input is inactive. A bit whose fault is still active stays set, so software cannot lose a condition that is still present. The per-channel masks and the summary mask are independent. To silence the alert for a channel fault, software must set the summary mask as well as that channel's mask. Limit comparison and the serial bus protocol live outside this block: the fault inputs arrive as boolean flags that have already been compared against their limits.

Top module: `fault_alert_unit`

## Requirements
- R1: After reset all four registers read 0x00 and `alert_n` is 1.
- R2: A fault input that is 1 for one cycle sets its status bit on the next clock edge, and the bit stays 1 after the input returns to 0.
- R3: A read strobe on a status address returns the value held before the read, then clears each bit of that register whose fault input is 0 in that cycle. A bit whose fault input is 1 during the read stays 1.
- R4: Address 1 is the channel status register. Bits 7:3 hold the sticky status of `chan_fault[4:0]`, with `chan_fault[0]` at bit 3. Bits 2:0 read 0.
- R5: Address 0 is the auxiliary status register. Bits 3:0 hold the sticky status of `aux_fault[3:0]`. Bit 7 is the summary bit and equals the OR of the five channel status bits. Bits 6:4 read 0.
- R6: Address 2 is the channel mask register, with bit 3+i masking channel i. Address 3 is the auxiliary mask register, with bits 3:0 masking the auxiliary sources and bit 7 masking the summary bit. Written values read back, except that the reserved bits (2:0 of address 2 and 6:4 of address 3) always read 0.
- R7: Writes to address 0 or address 1 have no effect.
- R8: `alert_n` is a register. It is 0 on the clock edge after any unmasked status bit, or an unmasked summary bit, is set. It returns to 1 on the edge after the last such contributor clears or is masked.
- R9: The summary mask is independent of the channel masks. With every channel masked but the summary mask clear, a set channel status bit still drives the alert. Only when both the channel mask and the summary mask are set is the alert suppressed.
- R10: A set auxiliary mask bit keeps its auxiliary status bit from driving the alert, while the status bit still latches and reads back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chan_fault | input | 5 | Live out-of-limit flags of the measurement channels |
| aux_fault | input | 4 | Live auxiliary fault flags |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (clears status on status addresses) |
| rd_data | output | 8 | Read data for `addr`, combinational |
| alert_n | output | 1 | Registered active-low alert |

## Verification
The assertions assume that the fault flags and the register strobes are synchronous to `clk` and stable around each rising edge. They also assume that a read strobe is held for exactly the cycle in which its data is taken. The bench changes every input on the falling edge and raises each strobe for one full cycle at a time. The bench never issues a write to a status address in the same cycle as a read or a new fault, so the checks of the ignored-write property see a quiet register.

// File: rtl/fault_alert_pkg.sv
package fault_alert_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned CHAN_N   = 5;
  localparam int unsigned AUX_N    = 4;
  localparam int unsigned CHAN_LSB = 3;
  localparam int unsigned SUM_BIT  = 7;
  localparam int unsigned ADDR_W   = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_AUX_STAT  = 2'd0,
    A_CHAN_STAT = 2'd1,
    A_CHAN_MASK = 2'd2,
    A_AUX_MASK  = 2'd3
  } reg_addr_e;

  localparam logic [DATA_W-1:0] CHAN_MASK_KEEP = 8'hF8;
  localparam logic [DATA_W-1:0] AUX_MASK_KEEP  = 8'h8F;

  // Next value of one sticky bit: live fault wins over a clearing read.
  function automatic logic sticky_next(input logic held, input logic live, input logic clr);
    return live | (held & ~clr);
  endfunction

  // Alert request from status and masks.
  function automatic logic alert_req(input logic [CHAN_N-1:0] cs, input logic [CHAN_N-1:0] cm,
                                     input logic [AUX_N-1:0] as, input logic [AUX_N-1:0] am,
                                     input logic sum_m);
    return (|(cs & ~cm)) | (|(as & ~am)) | ((|cs) & ~sum_m);
  endfunction
endpackage

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] live,
  input  logic         clr,
  output logic [N-1:0] held
);
  import fault_alert_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held[i] <= 1'b0;
      else        held[i] <= sticky_next(held[i], live[i], clr);
    end

    assert_set_on_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
      live[i] |=> held[i]);
    assert_keep_until_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (held[i] && !clr) |=> held[i]);
    assert_clear_when_gone_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !live[i]) |=> !held[i]);
  end
endmodule

// File: rtl/mask_reg.sv
module mask_reg #(
  parameter int unsigned          W    = 8,
  parameter logic [W-1:0]         KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata & KEEP;
  end

  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == ($past(wdata) & KEEP)));
endmodule

// File: rtl/alert_drive.sv
module alert_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic alert_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alert_n <= 1'b1;
    else        alert_n <= ~req;
  end

  assert_alert_on_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !alert_n);
  assert_alert_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> alert_n);
endmodule

// File: rtl/fault_alert_unit.sv
module fault_alert_unit
  import fault_alert_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAN_N-1:0] chan_fault,
  input  logic [AUX_N-1:0]  aux_fault,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              alert_n
);
  logic [CHAN_N-1:0] chan_stat;
  logic [AUX_N-1:0]  aux_stat;
  logic [DATA_W-1:0] chan_mask, aux_mask;
  logic              clr_chan, clr_aux, summary, req;
  logic              we_chan_mask, we_aux_mask, wr_status;

  assign clr_chan     = rd_en && (addr == A_CHAN_STAT);
  assign clr_aux      = rd_en && (addr == A_AUX_STAT);
  assign we_chan_mask = wr_en && (addr == A_CHAN_MASK);
  assign we_aux_mask  = wr_en && (addr == A_AUX_MASK);
  assign wr_status    = wr_en && ((addr == A_CHAN_STAT) || (addr == A_AUX_STAT));

  sticky_bank #(.N(CHAN_N)) u_chan (
    .clk(clk), .rst_n(rst_n), .live(chan_fault), .clr(clr_chan), .held(chan_stat));
  sticky_bank #(.N(AUX_N)) u_aux (
    .clk(clk), .rst_n(rst_n), .live(aux_fault), .clr(clr_aux), .held(aux_stat));

  mask_reg #(.W(DATA_W), .KEEP(CHAN_MASK_KEEP)) u_cmask (
    .clk(clk), .rst_n(rst_n), .we(we_chan_mask), .wdata(wr_data), .q(chan_mask));
  mask_reg #(.W(DATA_W), .KEEP(AUX_MASK_KEEP)) u_amask (
    .clk(clk), .rst_n(rst_n), .we(we_aux_mask), .wdata(wr_data), .q(aux_mask));

  assign summary = |chan_stat;
  assign req = alert_req(chan_stat, chan_mask[CHAN_LSB +: CHAN_N], aux_stat,
                         aux_mask[AUX_N-1:0], aux_mask[SUM_BIT]);

  alert_drive u_alert (.clk(clk), .rst_n(rst_n), .req(req), .alert_n(alert_n));

  always_comb begin
    rd_data = '0;
    unique case (addr)
      A_AUX_STAT: begin
        rd_data[AUX_N-1:0] = aux_stat;
        rd_data[SUM_BIT]   = summary;
      end
      A_CHAN_STAT: rd_data[CHAN_LSB +: CHAN_N] = chan_stat;
      A_CHAN_MASK: rd_data = chan_mask;
      A_AUX_MASK:  rd_data = aux_mask;
      default:     rd_data = '0;
    endcase
  end

  assert_status_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && !rd_en && chan_fault == '0 && aux_fault == '0)
      |=> ($stable(chan_stat) && $stable(aux_stat)));
  assert_summary_unmasked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|chan_stat) && !aux_mask[SUM_BIT]) |=> !alert_n);
  assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_mask[CHAN_LSB-1:0] == '0) && (aux_mask[SUM_BIT-1:AUX_N] == '0));
endmodule

// File: tb/fault_alert_unit_test.sv
module fault_alert_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] chan_fault = '0;
  logic [3:0] aux_fault = '0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       alert_n;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  fault_alert_unit uut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] c, input logic [3:0] x);
    chan_fault = c; aux_fault = x;
    @(negedge clk);
    chan_fault = '0; aux_fault = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 alert", {7'd0, alert_n}, 8'h01);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check("R1 regs", d, 8'h00);
    end
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    pulse(5'b00101, 4'h0);
    check("R8 latency", {7'd0, alert_n}, 8'h01);
    step();
    check("R8 assert", {7'd0, alert_n}, 8'h00);
    rd(2'd1, d);
    check("R2/R4 chan stat", d, 8'h28);
    check("R8 still low", {7'd0, alert_n}, 8'h00);
    step();
    check("R8 release", {7'd0, alert_n}, 8'h01);
    rd(2'd1, d);
    check("R3 cleared", d, 8'h00);
  endtask

  task automatic t_persist();
    logic [7:0] d;
    chan_fault = 5'b00010;
    step();
    rd(2'd1, d);
    check("R3 first", d, 8'h10);
    rd(2'd1, d);
    check("R3 held while active", d, 8'h10);
    chan_fault = '0;
    step();
    rd(2'd1, d);
    check("R3 latched after drop", d, 8'h10);
    rd(2'd1, d);
    check("R3 cleared after drop", d, 8'h00);
  endtask

  task automatic t_aux();
    logic [7:0] d;
    pulse(5'b10000, 4'b1001);
    rd(2'd0, d);
    check("R5 aux+summary", d, 8'h89);
    rd(2'd0, d);
    check("R5 summary only", d, 8'h80);
    rd(2'd1, d);
    check("R4 chan bit7", d, 8'h80);
    rd(2'd0, d);
    check("R5 summary clear", d, 8'h00);
  endtask

  task automatic t_masks();
    logic [7:0] d;
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    rd(2'd2, d);
    check("R6 chan mask", d, 8'hF8);
    rd(2'd3, d);
    check("R6 aux mask", d, 8'h8F);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'hFF);
    rd(2'd1, d);
    check("R7 chan stat", d, 8'h00);
    rd(2'd0, d);
    check("R7 aux stat", d, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);
    step();
    check("R7 alert idle", {7'd0, alert_n}, 8'h01);
  endtask

  task automatic t_summary();
    logic [7:0] d;
    wr(2'd2, 8'hF8);
    pulse(5'b00001, 4'h0);
    step();
    check("R9 summary alerts", {7'd0, alert_n}, 8'h00);
    wr(2'd3, 8'h80);
    step();
    check("R9 both masked", {7'd0, alert_n}, 8'h01);
    wr(2'd2, 8'h00);
    step();
    check("R9 chan unmasked", {7'd0, alert_n}, 8'h00);
    rd(2'd1, d);
    check("R9 stat", d, 8'h08);
    wr(2'd3, 8'h00);
    step();
    check("R8 idle", {7'd0, alert_n}, 8'h01);
  endtask

  task automatic t_auxmask();
    logic [7:0] d;
    wr(2'd3, 8'h0F);
    pulse(5'b0, 4'b0010);
    step();
    check("R10 masked", {7'd0, alert_n}, 8'h01);
    rd(2'd0, d);
    check("R10 latched", d, 8'h02);
    wr(2'd3, 8'h00);
    pulse(5'b0, 4'b0100);
    step();
    check("R10 unmasked", {7'd0, alert_n}, 8'h00);
    rd(2'd0, d);
    check("R10 stat", d, 8'h04);
    step();
    check("R8 aux release", {7'd0, alert_n}, 8'h01);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_sticky();
    t_persist();
    t_aux();
    t_masks();
    t_summary();
    t_auxmask();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule